// File: doc/BRIEF.md
# SMBus Host Register Front End

This block is the register file and transaction launcher of an SMBus host controller. Software reaches it through a byte-wide register port. The port carries a write strobe, a read strobe, an address and write data, and it returns read data combinationally. Software sets up a target address, a command byte and up to two data bytes. It then writes the control register with the go bit set and a protocol code. The block checks that the code is legal for the chosen direction. It then sends a single request to a backend, which does the bit-level bus work, and waits for one response.

The backend link has two streams, both with valid/ready handshakes. The request stream holds `be_req_valid` high, with every request field stable, until the backend raises `be_req_ready`. It has no combinational path from ready to valid. The response stream raises `be_rsp_ready` only while a request is outstanding. A response transfers on the cycle where valid and ready are both high, so the backend may hold a response for as long as it wants. At most one transaction is in flight. When a response arrives, the block updates the data registers and the status flags. A level interrupt output reports any pending status while interrupts are enabled.

With interrupts disabled, a go write only marks the host busy. The transaction launches on the next read of the status register, and that read still returns the busy flag. This supports software that waits for busy to appear before it starts polling.

Top module: `smb_host_regs`

## Requirements
- R1: Every register resets to 0. Software can read back what it writes to the target register (offset 0x04: bit 0 is the direction, 1 = read, and bits 7:1 are the 7-bit target), the command (0x03), data low (0x05), data high (0x06) and block byte (0x07) registers. The auxiliary register (0x0D) keeps only bits 1:0. Any other offset reads 0 and ignores writes.
- R2: A read of the control register (0x02) returns only bits 4:0 of the last value written: bit 0 interrupt enable, bit 1 kill, bits 4:2 protocol. The go bit (bit 6) always reads back as 0.
- R3: A write to the status register (0x00) clears each status bit written as 1. Busy (bit 0) is never cleared by this write.
- R4: A go write with interrupt enable set launches at once. It produces exactly one request that carries the protocol code, the target address (bits 7:1 of 0x04), the direction (bit 0 of 0x04), the command byte, and data {data high, data low}.
- R5: A go write with interrupt enable clear sets busy and sends no request. The next status read returns busy = 1 and launches the request.
- R6: A request stays valid with stable fields until it is accepted. A response is accepted only after that request has been accepted.
- R7: A successful response sets done (status bit 1) and clears busy. On a read, protocols 1, 2, 5 and 6 load response bits 7:0 into data low. Protocol 3 loads bits 7:0 into data low and bits 15:8 into data high. Writes and quick commands (protocol 0) leave the data registers unchanged.
- R8: An error response sets device error (status bit 2) and clears busy. The data registers stay unchanged.
- R9: Protocol codes 4 and 7, and code 6 with direction write, send no request. They set device error and clear busy.
- R10: While device error is set, any launch (immediate or deferred) sends no request. Device error stays set and busy clears.
- R11: A control write with kill set does three things: it sets failed (status bit 4), clears busy, and cancels a deferred start. If a transaction is in flight, its response is later consumed and discarded, so neither the status nor the data registers change.
- R12: `irq` is high exactly when interrupt enable is set and any of status bits 7:1 is set.
- R13: A go write made while a transaction is still outstanding is ignored. No second request is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (status read may launch) |
| reg_addr | input | AW | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| be_req_valid | output | 1 | Request valid |
| be_req_ready | input | 1 | Request accepted by backend |
| be_req_proto | output | 3 | Protocol code |
| be_req_taddr | output | 7 | 7-bit target address |
| be_req_read | output | 1 | Direction, 1 = read |
| be_req_cmd | output | 8 | Command byte |
| be_req_data | output | 16 | {data high, data low} |
| be_rsp_valid | input | 1 | Response valid |
| be_rsp_ready | output | 1 | Response can be taken |
| be_rsp_err | input | 1 | Response reports a failure |
| be_rsp_data | input | 16 | Read data returned |
| irq | output | 1 | Level interrupt |

## Verification
The hardest situation to reach from the ports is a kill that lands while a transaction is in flight. The kill must arrive after the backend has taken the request and before it answers, and the late response must then leave no trace. The stimulus reaches this by slowing the backend model's response by ten cycles, issuing the kill right after the request handshake, and checking the status and data low registers after the response has been drained. The deferred start is the second case that needs care, because any status read in the wrong place launches it. The bench therefore clears status with a write and leaves several idle cycles before the single read that triggers the launch.

// File: rtl/smb_host_pkg.sv
package smb_host_pkg;

  // register offsets
  localparam int OFS_STS = 'h00;
  localparam int OFS_CTL = 'h02;
  localparam int OFS_CMD = 'h03;
  localparam int OFS_ADR = 'h04;
  localparam int OFS_DLO = 'h05;
  localparam int OFS_DHI = 'h06;
  localparam int OFS_BLK = 'h07;
  localparam int OFS_AUX = 'h0D;

  // status bit positions
  localparam int ST_BUSY    = 0;
  localparam int ST_DONE    = 1;
  localparam int ST_DEVERR  = 2;
  localparam int ST_BUSERR  = 3;
  localparam int ST_FAILED  = 4;
  localparam int ST_ALERT   = 5;
  localparam int ST_INUSE   = 6;
  localparam int ST_BYTEDN  = 7;

  // control bit positions
  localparam int CT_IEN  = 0;
  localparam int CT_KILL = 1;
  localparam int CT_PLO  = 2;
  localparam int CT_GO   = 6;

  localparam int CTL_KEEP_W = 5;
  localparam int AUX_W      = 2;
  localparam int TADDR_W    = 7;

  typedef enum logic [2:0] {
    PR_QUICK   = 3'd0,
    PR_BYTE    = 3'd1,
    PR_BDATA   = 3'd2,
    PR_WORD    = 3'd3,
    PR_CALL    = 3'd4,
    PR_BLOCK   = 3'd5,
    PR_I2CRD   = 3'd6,
    PR_RSVD    = 3'd7
  } proto_e;

  typedef enum logic [1:0] {
    EN_IDLE = 2'd0,
    EN_REQ  = 2'd1,
    EN_WAIT = 2'd2
  } eng_state_e;

  typedef struct packed {
    proto_e              proto;
    logic [TADDR_W-1:0]  taddr;
    logic                rd;
    logic [7:0]          cmd;
    logic [15:0]         data;
  } smb_req_t;

  // which data registers a successful response loads: {high, low}
  function automatic logic [1:0] rsp_lanes(input proto_e p, input logic rd);
    logic [1:0] l;
    l = 2'b00;
    if (rd) begin
      unique case (p)
        PR_BYTE, PR_BDATA, PR_BLOCK, PR_I2CRD: l = 2'b01;
        PR_WORD:                               l = 2'b11;
        default:                               l = 2'b00;
      endcase
    end
    return l;
  endfunction

endpackage

// File: rtl/smb_proto_check.sv
module smb_proto_check
  import smb_host_pkg::*;
(
  input  proto_e proto,
  input  logic   rd,
  output logic   legal
);
  always_comb begin
    unique case (proto)
      PR_QUICK, PR_BYTE, PR_BDATA, PR_WORD, PR_BLOCK: legal = 1'b1;
      PR_I2CRD:                                       legal = rd;
      default:                                        legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/smb_txn_engine.sv
module smb_txn_engine
  import smb_host_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go_i,
  input  smb_req_t   req_i,
  input  logic       kill_i,
  output logic       idle_o,
  output logic       req_valid_o,
  input  logic       req_ready_i,
  output smb_req_t   req_o,
  input  logic       rsp_valid_i,
  output logic       rsp_ready_o,
  input  logic       rsp_err_i,
  output logic       done_ok_o,
  output logic       done_err_o,
  output logic [1:0] lanes_o
);
  eng_state_e state_q;
  smb_req_t   req_q;
  logic       drop_q;
  logic       accept;

  assign idle_o      = (state_q == EN_IDLE);
  assign req_valid_o = (state_q == EN_REQ);
  assign rsp_ready_o = (state_q == EN_WAIT);
  assign req_o       = req_q;
  assign accept      = rsp_ready_o && rsp_valid_i;
  assign done_ok_o   = accept && !drop_q && !kill_i && !rsp_err_i;
  assign done_err_o  = accept && !drop_q && !kill_i && rsp_err_i;
  assign lanes_o     = rsp_lanes(req_q.proto, req_q.rd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= EN_IDLE;
      req_q   <= '0;
      drop_q  <= 1'b0;
    end else begin
      unique case (state_q)
        EN_IDLE: if (go_i) begin
          req_q   <= req_i;
          state_q <= EN_REQ;
        end
        EN_REQ:  if (req_ready_i) state_q <= EN_WAIT;
        EN_WAIT: if (rsp_valid_i) state_q <= EN_IDLE;
        default: state_q <= EN_IDLE;
      endcase
      if (accept)                        drop_q <= 1'b0;
      else if (kill_i && !idle_o)        drop_q <= 1'b1;
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_o)); // R6

  AST_GO_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    go_i |-> idle_o); // R13

endmodule

// File: rtl/smb_host_regs.sv
module smb_host_regs
  import smb_host_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  output logic          be_req_valid,
  input  logic          be_req_ready,
  output logic [2:0]    be_req_proto,
  output logic [6:0]    be_req_taddr,
  output logic          be_req_read,
  output logic [7:0]    be_req_cmd,
  output logic [15:0]   be_req_data,
  input  logic          be_rsp_valid,
  output logic          be_rsp_ready,
  input  logic          be_rsp_err,
  input  logic [15:0]   be_rsp_data,
  output logic          irq
);
  localparam logic [AW-1:0] A_STS = AW'(OFS_STS);
  localparam logic [AW-1:0] A_CTL = AW'(OFS_CTL);
  localparam logic [AW-1:0] A_CMD = AW'(OFS_CMD);
  localparam logic [AW-1:0] A_ADR = AW'(OFS_ADR);
  localparam logic [AW-1:0] A_DLO = AW'(OFS_DLO);
  localparam logic [AW-1:0] A_DHI = AW'(OFS_DHI);
  localparam logic [AW-1:0] A_BLK = AW'(OFS_BLK);
  localparam logic [AW-1:0] A_AUX = AW'(OFS_AUX);

  logic [7:0]            stat_q, stat_n;
  logic [CTL_KEEP_W-1:0] ctrl_q;
  logic [7:0]            cmd_q, adr_q, dlo_q, dhi_q, blk_q;
  logic [AUX_W-1:0]      aux_q;
  logic                  pend_q, pend_n;

  logic       sts_wr, ctl_wr, kill_wr, start_wr, sts_rd, defer_go;
  logic       launch, legal, bad_launch, go;
  proto_e     launch_proto;
  smb_req_t   launch_req, cur_req;
  logic       eng_idle, eng_ok, eng_err;
  logic [1:0] lanes;

  // ---------------- access decode ----------------
  assign sts_wr   = reg_wr && (reg_addr == A_STS);
  assign ctl_wr   = reg_wr && (reg_addr == A_CTL);
  assign sts_rd   = reg_rd && (reg_addr == A_STS);
  assign kill_wr  = ctl_wr && reg_wdata[CT_KILL];
  assign start_wr = ctl_wr && reg_wdata[CT_GO] && !reg_wdata[CT_KILL] && eng_idle;
  assign defer_go = sts_rd && pend_q && eng_idle;
  assign launch   = (start_wr && reg_wdata[CT_IEN]) || defer_go;

  assign launch_proto = start_wr ? proto_e'(reg_wdata[CT_PLO+:3])
                                 : proto_e'(ctrl_q[CT_PLO+:3]);

  always_comb begin
    launch_req.proto = launch_proto;
    launch_req.taddr = adr_q[7:1];
    launch_req.rd    = adr_q[0];
    launch_req.cmd   = cmd_q;
    launch_req.data  = {dhi_q, dlo_q};
  end

  smb_proto_check u_check (
    .proto (launch_proto),
    .rd    (adr_q[0]),
    .legal (legal)
  );

  assign bad_launch = launch && (!legal || stat_q[ST_DEVERR]);
  assign go         = launch && legal && !stat_q[ST_DEVERR];

  smb_txn_engine u_eng (
    .clk         (clk),
    .rst_n       (rst_n),
    .go_i        (go),
    .req_i       (launch_req),
    .kill_i      (kill_wr),
    .idle_o      (eng_idle),
    .req_valid_o (be_req_valid),
    .req_ready_i (be_req_ready),
    .req_o       (cur_req),
    .rsp_valid_i (be_rsp_valid),
    .rsp_ready_o (be_rsp_ready),
    .rsp_err_i   (be_rsp_err),
    .done_ok_o   (eng_ok),
    .done_err_o  (eng_err),
    .lanes_o     (lanes)
  );

  assign be_req_proto = cur_req.proto;
  assign be_req_taddr = cur_req.taddr;
  assign be_req_read  = cur_req.rd;
  assign be_req_cmd   = cur_req.cmd;
  assign be_req_data  = cur_req.data;

  // ---------------- status and pending start ----------------
  always_comb begin
    stat_n = stat_q;
    if (sts_wr) stat_n = stat_n & ~(reg_wdata & 8'hFE);
    if (start_wr) stat_n[ST_BUSY] = 1'b1;
    if (eng_ok) begin
      stat_n[ST_DONE] = 1'b1;
      stat_n[ST_BUSY] = 1'b0;
    end
    if (eng_err || bad_launch) begin
      stat_n[ST_DEVERR] = 1'b1;
      stat_n[ST_BUSY]   = 1'b0;
    end
    if (kill_wr) begin
      stat_n[ST_FAILED] = 1'b1;
      stat_n[ST_BUSY]   = 1'b0;
    end
  end

  always_comb begin
    pend_n = pend_q;
    if (start_wr) pend_n = !reg_wdata[CT_IEN];
    if (defer_go) pend_n = 1'b0;
    if (kill_wr)  pend_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      pend_q <= 1'b0;
    end else begin
      stat_q <= stat_n;
      pend_q <= pend_n;
    end
  end

  // ---------------- configuration and data registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      cmd_q  <= '0;
      adr_q  <= '0;
      dlo_q  <= '0;
      dhi_q  <= '0;
      blk_q  <= '0;
      aux_q  <= '0;
    end else begin
      if (reg_wr) begin
        unique case (reg_addr)
          A_CTL:   ctrl_q <= reg_wdata[CTL_KEEP_W-1:0];
          A_CMD:   cmd_q  <= reg_wdata;
          A_ADR:   adr_q  <= reg_wdata;
          A_DLO:   dlo_q  <= reg_wdata;
          A_DHI:   dhi_q  <= reg_wdata;
          A_BLK:   blk_q  <= reg_wdata;
          A_AUX:   aux_q  <= reg_wdata[AUX_W-1:0];
          default: ;
        endcase
      end
      if (eng_ok && lanes[0]) dlo_q <= be_rsp_data[7:0];
      if (eng_ok && lanes[1]) dhi_q <= be_rsp_data[15:8];
    end
  end

  // ---------------- read mux and interrupt ----------------
  always_comb begin
    unique case (reg_addr)
      A_STS:   reg_rdata = stat_q;
      A_CTL:   reg_rdata = {{(8-CTL_KEEP_W){1'b0}}, ctrl_q};
      A_CMD:   reg_rdata = cmd_q;
      A_ADR:   reg_rdata = adr_q;
      A_DLO:   reg_rdata = dlo_q;
      A_DHI:   reg_rdata = dhi_q;
      A_BLK:   reg_rdata = blk_q;
      A_AUX:   reg_rdata = {{(8-AUX_W){1'b0}}, aux_q};
      default: reg_rdata = 8'h00;
    endcase
  end

  assign irq = ctrl_q[CT_IEN] && (|stat_q[7:1]);

  // ---------------- assertions ----------------
  AST_BUSY_SURVIVES_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    sts_wr && stat_q[ST_BUSY] && !eng_ok && !eng_err && !bad_launch
    |=> stat_q[ST_BUSY]); // R3

  AST_DEFER_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    start_wr && !reg_wdata[CT_IEN] |=> stat_q[ST_BUSY] && !be_req_valid); // R5

  AST_DONE_CLEARS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    eng_ok |=> stat_q[ST_DONE] && !stat_q[ST_BUSY]); // R7

  AST_DEVERR_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    launch && stat_q[ST_DEVERR] |=> !be_req_valid && stat_q[ST_DEVERR]); // R10

  AST_KILL_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
    kill_wr |=> stat_q[ST_FAILED] && !stat_q[ST_BUSY]); // R11

endmodule

// File: tb/smb_host_regs_tb.sv
`timescale 1ns/1ps
module smb_host_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0, reg_rdata;
  logic        be_req_valid, be_req_ready = 1'b0;
  logic [2:0]  be_req_proto;
  logic [6:0]  be_req_taddr;
  logic        be_req_read;
  logic [7:0]  be_req_cmd;
  logic [15:0] be_req_data;
  logic        be_rsp_valid = 1'b0, be_rsp_ready, be_rsp_err = 1'b0;
  logic [15:0] be_rsp_data = '0;
  logic        irq;

  int checks = 0, errors = 0, req_cnt = 0;
  int rdy_dly = 0, rsp_dly = 2;
  logic        nxt_err = 1'b0;
  logic [15:0] nxt_data = '0;
  logic [34:0] exp_q[$];

  always #2 clk = ~clk;

  smb_host_regs #(.AW(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .be_req_valid(be_req_valid), .be_req_ready(be_req_ready),
    .be_req_proto(be_req_proto), .be_req_taddr(be_req_taddr),
    .be_req_read(be_req_read), .be_req_cmd(be_req_cmd), .be_req_data(be_req_data),
    .be_rsp_valid(be_rsp_valid), .be_rsp_ready(be_rsp_ready),
    .be_rsp_err(be_rsp_err), .be_rsp_data(be_rsp_data), .irq(irq)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rchk(input logic [3:0] a, input logic [7:0] exp, input string tag);
    logic [7:0] v;
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    #1 v = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
    check(tag, v, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_req(input logic [2:0] p, input logic [6:0] t, input logic r,
                          input logic [7:0] c, input logic [15:0] d);
    exp_q.push_back({p, t, r, c, d});
  endtask

  // backend model
  initial begin
    forever begin
      @(negedge clk);
      if (be_req_valid) begin
        repeat (rdy_dly) @(negedge clk);
        be_req_ready = 1'b1;
        @(negedge clk);
        be_req_ready = 1'b0;
        repeat (rsp_dly) @(negedge clk);
        be_rsp_valid = 1'b1; be_rsp_err = nxt_err; be_rsp_data = nxt_data;
        @(negedge clk);
        be_rsp_valid = 1'b0; be_rsp_err = 1'b0;
      end
    end
  end

  // scoreboard monitor: handshake seen just after a falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (be_req_valid && be_req_ready) begin
        req_cnt++;
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R4 unexpected request: actual 0x%0h expected none",
                   {be_req_proto, be_req_taddr, be_req_read, be_req_cmd, be_req_data});
        end else begin
          check("R4/R6 request fields",
                {be_req_proto, be_req_taddr, be_req_read, be_req_cmd, be_req_data},
                exp_q.pop_front());
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  int c0;
  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    rchk(4'h0, 8'h00, "R1 reset status");
    rchk(4'h2, 8'h00, "R1 reset control");
    check("R12 reset irq", irq, 0);
    check("R1 reset req_valid", be_req_valid, 0);

    // R1 register readback
    wr(4'h4, 8'hA5); rchk(4'h4, 8'hA5, "R1 target reg");
    wr(4'h3, 8'h3C); rchk(4'h3, 8'h3C, "R1 command reg");
    wr(4'h5, 8'h11); rchk(4'h5, 8'h11, "R1 data low");
    wr(4'h6, 8'h22); rchk(4'h6, 8'h22, "R1 data high");
    wr(4'h7, 8'h77); rchk(4'h7, 8'h77, "R1 block byte");
    wr(4'hD, 8'hFF); rchk(4'hD, 8'h03, "R1 aux keeps 2 bits");
    wr(4'h1, 8'h55); rchk(4'h1, 8'h00, "R1 unmapped reads 0");
    rchk(4'hE, 8'h00, "R1 unmapped 0x0E");

    // R2 control readback
    wr(4'h2, 8'hBC); rchk(4'h2, 8'h1C, "R2 control low bits only");

    // R4 immediate word write, R6 slow ready
    wr(4'h4, 8'hA0);
    rdy_dly = 3; rsp_dly = 2; nxt_err = 0; nxt_data = 16'h0000;
    push_req(3'd3, 7'h50, 1'b0, 8'h3C, 16'h2211);
    wr(4'h2, 8'h4D);
    rchk(4'h2, 8'h0D, "R2 go bit reads 0");
    idle(20);
    rchk(4'h0, 8'h02, "R4 done after word write");
    check("R12 irq with ien and done", irq, 1);
    rchk(4'h5, 8'h11, "R7 write leaves data low");

    // R3 clear
    wr(4'h0, 8'hFF);
    rchk(4'h0, 8'h00, "R3 w1c clears done");
    check("R12 irq low after clear", irq, 0);

    // R5 deferred byte read, R3 busy survives
    rdy_dly = 0;
    wr(4'h4, 8'hA1);
    c0 = req_cnt;
    wr(4'h2, 8'h48);
    idle(5);
    check("R5 no request before status read", req_cnt, c0);
    check("R5 req_valid low while deferred", be_req_valid, 0);
    wr(4'h0, 8'hFF);
    nxt_data = 16'hBEEF;
    push_req(3'd2, 7'h50, 1'b1, 8'h3C, 16'h2211);
    rchk(4'h0, 8'h01, "R3 busy kept / R5 read returns busy");
    idle(20);
    check("R5 request launched by read", req_cnt, c0 + 1);
    rchk(4'h0, 8'h02, "R5 done after deferred run");
    rchk(4'h5, 8'hEF, "R7 byte read data low");
    rchk(4'h6, 8'h22, "R7 byte read keeps data high");
    check("R12 irq masked when ien clear", irq, 0);
    wr(4'h0, 8'hFF);

    // R7 word read
    nxt_data = 16'hCAFE;
    push_req(3'd3, 7'h50, 1'b1, 8'h3C, 16'h22EF);
    wr(4'h2, 8'h4D);
    idle(20);
    rchk(4'h0, 8'h02, "R7 word read done");
    rchk(4'h5, 8'hFE, "R7 word read low");
    rchk(4'h6, 8'hCA, "R7 word read high");
    wr(4'h0, 8'hFF);

    // R8 backend error
    nxt_err = 1; nxt_data = 16'h1111;
    push_req(3'd1, 7'h50, 1'b1, 8'h3C, 16'hCAFE);
    wr(4'h2, 8'h45);
    idle(20);
    rchk(4'h0, 8'h04, "R8 device error, busy clear");
    rchk(4'h5, 8'hFE, "R8 data unchanged");
    check("R12 irq on device error", irq, 1);

    // R10 device error blocks launches
    c0 = req_cnt;
    wr(4'h2, 8'h41);
    idle(10);
    rchk(4'h0, 8'h04, "R10 immediate start blocked");
    wr(4'h2, 8'h40);
    rchk(4'h0, 8'h05, "R10 deferred read shows busy");
    idle(10);
    rchk(4'h0, 8'h04, "R10 deferred launch blocked");
    check("R10 no request sent", req_cnt, c0);
    wr(4'h0, 8'hFF); nxt_err = 0;
    rchk(4'h0, 8'h00, "R3 device error cleared");

    // R9 illegal protocols
    wr(4'h2, 8'h51); idle(5);
    rchk(4'h0, 8'h04, "R9 protocol 4 rejected"); wr(4'h0, 8'hFF);
    wr(4'h4, 8'hA0);
    wr(4'h2, 8'h59); idle(5);
    rchk(4'h0, 8'h04, "R9 protocol 6 write rejected"); wr(4'h0, 8'hFF);
    wr(4'h2, 8'h5D); idle(5);
    rchk(4'h0, 8'h04, "R9 protocol 7 rejected"); wr(4'h0, 8'hFF);
    check("R9 no request for illegal codes", req_cnt, c0);
    wr(4'h4, 8'hA1);
    nxt_data = 16'h0033;
    push_req(3'd6, 7'h50, 1'b1, 8'h3C, 16'hCAFE);
    wr(4'h2, 8'h59);
    idle(20);
    rchk(4'h0, 8'h02, "R9 protocol 6 read accepted");
    rchk(4'h5, 8'h33, "R7 protocol 6 read data low");
    wr(4'h0, 8'hFF);

    // R11 kill cancels a deferred start
    c0 = req_cnt;
    wr(4'h2, 8'h48);
    wr(4'h2, 8'h02);
    rchk(4'h0, 8'h10, "R11 kill sets failed, clears busy");
    idle(5);
    check("R11 deferred start cancelled", req_cnt, c0);
    wr(4'h0, 8'hFF);

    // R11 kill while in flight
    rsp_dly = 10; nxt_data = 16'h1234;
    push_req(3'd1, 7'h50, 1'b1, 8'h3C, 16'hCA33);
    wr(4'h2, 8'h45);
    wr(4'h2, 8'h03);
    rchk(4'h0, 8'h10, "R11 kill in flight");
    check("R12 irq on failed", irq, 1);
    idle(25);
    rchk(4'h0, 8'h10, "R11 late response ignored");
    rchk(4'h5, 8'h33, "R11 data low untouched");
    wr(4'h0, 8'hFF);

    // R13 second start while in flight
    nxt_data = 16'h5A5A;
    push_req(3'd1, 7'h50, 1'b1, 8'h3C, 16'hCA33);
    c0 = req_cnt;
    wr(4'h2, 8'h45);
    wr(4'h2, 8'h45);
    rchk(4'h0, 8'h01, "R13 busy while in flight");
    idle(25);
    rchk(4'h0, 8'h02, "R13 single completion");
    rchk(4'h5, 8'h5A, "R7 byte receive data low");
    check("R13 exactly one request", req_cnt, c0 + 1);

    check("R4 all expected requests seen", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule